// File: doc/BRIEF.md
# Wake Interrupt Polarity Conditioner

This block sits between a bank of interrupt sources and a parent interrupt controller that accepts only rising-edge pulses or active-high levels. Each input pin has its own enable bit and a 3-bit trigger type. The block synchronises each raw input and then converts it for the parent. An active-low level is inverted into an active-high level. A falling edge becomes a one-clock rising pulse. In dual-edge mode, every transition becomes a one-clock rising pulse. Rising-edge and active-high inputs pass through in the same form.

Software programs the block through a flat 32-bit register port. The enable bits are packed 32 to a word. The trigger types take one word per pin. To change one pin's enable, software reads the word, changes the one bit and writes the word back, so the other pins in that word keep their values. A pin that is disabled, or whose type code is not defined, holds its output low.

Top module: `wake_irq_conditioner`

## Requirements
- R1: After a synchronous active-low reset, every enable bit and every type field reads zero and every output is low.
- R2: The enable words start at byte address 0x10 at a stride of 4. Pin p uses bit p%32 of word p/32. A write changes only that word. Bits above the last implemented pin read zero.
- R3: Pin p's type field is held in bits [2:0] of the word at byte address 0x110 + 4*p. The upper bits of that word read zero.
- R4: Type 3'b100 (level, active high): the output equals the input, three clocks after the input changes.
- R5: Type 3'b000 (level, active low): the output equals the inverted input, with the same three-clock latency.
- R6: Type 3'b110 (rising edge): each rising input edge gives exactly one one-clock high pulse. A falling edge gives none.
- R7: Type 3'b010 (falling edge): each falling input edge gives exactly one one-clock high pulse. A rising edge gives none.
- R8: Type 3'b111 (dual edge): every input edge, rising or falling, gives exactly one one-clock high pulse.
- R9: A disabled pin drives its output low within one clock and ignores input edges. Enabling a pin whose input is already steady produces no pulse.
- R10: The undefined type codes 3'b001, 3'b011 and 3'b101 hold the output low.
- R11: Reads of addresses outside the implemented enable words and type words return zero. Writes to those addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 12 | Byte address, word aligned |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_in | input | NUM_PINS | Raw interrupt inputs, asynchronous |
| irq_out | output | NUM_PINS | Conditioned outputs to the parent |

## Verification
Some rules are checked by the assertions on every clock. These are: a disabled pin and an undefined type code never raise the output, an edge-mode pulse never lasts past one clock while the mode holds, and an active-low level input that is high never gives a high output. Other behaviour can be shown only by the bench scenarios. This covers the register address map and the word masking, the exact three-clock latency, and the pulse count for each mode and edge direction. It also covers the absence of a pulse when a pin is enabled while its input is already steady, and the handling of out-of-range addresses.

// File: rtl/wic_pkg.sv
// Package for the wake interrupt conditioner.
// Holds the trigger-type codes and the register address map.
// Assumes byte addressing with 32-bit words.
package wic_pkg;
    localparam logic [2:0] TRIG_LVL_LOW  = 3'b000;
    localparam logic [2:0] TRIG_FALL     = 3'b010;
    localparam logic [2:0] TRIG_LVL_HIGH = 3'b100;
    localparam logic [2:0] TRIG_RISE     = 3'b110;
    localparam logic [2:0] TRIG_BOTH     = 3'b111;

    localparam int EN_BASE  = 'h10;
    localparam int CFG_BASE = 'h110;
endpackage

// File: rtl/wic_regs.sv
// Register file for the conditioner: packed enable words and one type word per pin.
// Assumes word-aligned accesses. Addresses that are not aligned or not mapped
// read zero and ignore writes.
module wic_regs
    import wic_pkg::*;
#(
    parameter int NUM_PINS = 168,
    parameter int ADDR_W   = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    output logic [NUM_PINS-1:0]   en_vec,
    output logic [3*NUM_PINS-1:0] cfg_flat
);
    localparam int NWORDS = (NUM_PINS + 31) / 32;
    localparam int EN_END  = EN_BASE + 4 * NWORDS;
    localparam int CFG_END = CFG_BASE + 4 * NUM_PINS;

    logic [NUM_PINS-1:0] en_q;
    logic [2:0]          cfg_q [NUM_PINS];
    logic                en_hit, cfg_hit;
    logic [ADDR_W-1:0]   en_off, cfg_off;
    logic [ADDR_W-1:0]   widx, cidx;

    // Decode the address into an enable-word index or a type-word index.
    always_comb begin
        en_off  = reg_addr - ADDR_W'(EN_BASE);
        cfg_off = reg_addr - ADDR_W'(CFG_BASE);
        widx    = en_off >> 2;
        cidx    = cfg_off >> 2;
        en_hit  = (reg_addr[1:0] == 2'b00) && (reg_addr >= ADDR_W'(EN_BASE))
                  && (reg_addr < ADDR_W'(EN_END));
        cfg_hit = (reg_addr[1:0] == 2'b00) && (reg_addr >= ADDR_W'(CFG_BASE))
                  && (reg_addr < ADDR_W'(CFG_END));
    end

    // Store writes. Reset clears every enable bit and every type field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
            for (int p = 0; p < NUM_PINS; p++) cfg_q[p] <= 3'b000;
        end else if (reg_wr) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if (en_hit && widx == ADDR_W'(p / 32)) en_q[p] <= reg_wdata[p % 32];
                if (cfg_hit && cidx == ADDR_W'(p)) cfg_q[p] <= reg_wdata[2:0];
            end
        end
    end

    // Read mux. Unmapped addresses and unimplemented bits return zero.
    always_comb begin
        reg_rdata = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (en_hit && widx == ADDR_W'(p / 32)) reg_rdata[p % 32] = en_q[p];
            if (cfg_hit && cidx == ADDR_W'(p)) reg_rdata[2:0] = cfg_q[p];
        end
    end

    // Flatten the stored state for the per-pin conditioners.
    always_comb begin
        en_vec = en_q;
        for (int p = 0; p < NUM_PINS; p++) cfg_flat[3*p +: 3] = cfg_q[p];
    end
endmodule

// File: rtl/wic_pin.sv
// Conditioner for one pin. It synchronises the raw input through two flops,
// keeps one cycle of history, and forms a registered output to the parent.
// Assumes the enable and type inputs are already in this clock domain.
// The history follows the input even while the pin is disabled, so enabling
// the pin never creates a pulse.
module wic_pin
    import wic_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [2:0] cfg,
    input  logic       raw,
    output logic       out
);
    logic sync_a, sync_b, prev, out_q, nxt;

    // Synchronise the input, keep one cycle of history and register the output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_a <= 1'b0;
            sync_b <= 1'b0;
            prev   <= 1'b0;
            out_q  <= 1'b0;
        end else begin
            sync_a <= raw;
            sync_b <= sync_a;
            prev   <= sync_b;
            out_q  <= nxt;
        end
    end

    // Convert the input by trigger type. Undefined codes and a disabled pin give low.
    always_comb begin
        case (cfg)
            TRIG_LVL_HIGH: nxt = sync_b;
            TRIG_LVL_LOW:  nxt = ~sync_b;
            TRIG_RISE:     nxt = sync_b & ~prev;
            TRIG_FALL:     nxt = ~sync_b & prev;
            TRIG_BOTH:     nxt = sync_b ^ prev;
            default:       nxt = 1'b0;
        endcase
        if (!en) nxt = 1'b0;
    end

    assign out = out_q;

    // R9: a disabled pin has a low output on the next clock.
    a_r9_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !out_q);

    // R10: an undefined type code gives a low output on the next clock.
    a_r10_unused_low: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg == 3'b001 || cfg == 3'b011 || cfg == 3'b101) |=> !out_q);

    // R6: a rising-edge pulse lasts one clock while the mode holds.
    a_r6_rise_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q && cfg == TRIG_RISE && $past(cfg) == TRIG_RISE) |=> !out_q);

    // R7: a falling-edge pulse lasts one clock while the mode holds.
    a_r7_fall_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q && cfg == TRIG_FALL && $past(cfg) == TRIG_FALL) |=> !out_q);

    // R5: an active-low level input that is high gives a low output.
    a_r5_low_level_inverted: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg == TRIG_LVL_LOW && sync_b) |=> !out_q);
endmodule

// File: rtl/wake_irq_conditioner.sv
// Top of the wake interrupt polarity conditioner: a register file plus one
// conditioner per pin. Assumes one clock domain for the register port and the
// outputs. The interrupt inputs may be asynchronous.
module wake_irq_conditioner #(
    parameter int NUM_PINS = 168,
    parameter int ADDR_W   = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic [NUM_PINS-1:0] irq_in,
    output logic [NUM_PINS-1:0] irq_out
);
    logic [NUM_PINS-1:0]   en_vec;
    logic [3*NUM_PINS-1:0] cfg_flat;

    wic_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .en_vec(en_vec), .cfg_flat(cfg_flat)
    );

    // One conditioner for each pin.
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        wic_pin u_pin (
            .clk(clk), .rst_n(rst_n), .en(en_vec[p]), .cfg(cfg_flat[3*p +: 3]),
            .raw(irq_in[p]), .out(irq_out[p])
        );
    end
endmodule

// File: tb/sim_wake_irq_conditioner.sv
module sim_wake_irq_conditioner;
    localparam int NP  = 168;
    localparam int PIN = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [11:0]   reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NP-1:0] irq_in = '0;
    logic [NP-1:0] irq_out;

    int n_chk = 0;
    int n_fail = 0;

    wake_irq_conditioner #(.NUM_PINS(NP), .ADDR_W(12)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in), .irq_out(irq_out)
    );

    always #10 clk = ~clk;

    // Vector fields: {type[2:0], en, start, end, level_before, count[3:0]}
    localparam logic [10:0] VEC [14] = '{
        {3'b100, 1'b1, 1'b0, 1'b1, 1'b0, 4'd6},
        {3'b100, 1'b1, 1'b1, 1'b0, 1'b1, 4'd2},
        {3'b000, 1'b1, 1'b0, 1'b1, 1'b1, 4'd2},
        {3'b000, 1'b1, 1'b1, 1'b0, 1'b0, 4'd6},
        {3'b110, 1'b1, 1'b0, 1'b1, 1'b0, 4'd1},
        {3'b110, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0},
        {3'b010, 1'b1, 1'b1, 1'b0, 1'b0, 4'd1},
        {3'b010, 1'b1, 1'b0, 1'b1, 1'b0, 4'd0},
        {3'b111, 1'b1, 1'b0, 1'b1, 1'b0, 4'd1},
        {3'b111, 1'b1, 1'b1, 1'b0, 1'b0, 4'd1},
        {3'b001, 1'b1, 1'b0, 1'b1, 1'b0, 4'd0},
        {3'b011, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0},
        {3'b101, 1'b1, 1'b0, 1'b1, 1'b0, 4'd0},
        {3'b100, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0}
    };

    function automatic string tag_of(input logic [2:0] t, input logic e);
        if (!e) return "R9";
        case (t)
            3'b100: return "R4";
            3'b000: return "R5";
            3'b110: return "R6";
            3'b010: return "R7";
            3'b111: return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 12'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = 12'(a);
        #1 d = reg_rdata;
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Drive pin p to v at a falling clock edge, then count high outputs over 8 cycles.
    task automatic edge_count(input int p, input logic v, output int cnt);
        @(negedge clk);
        irq_in[p] = v;
        cnt = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (irq_out[p]) cnt++;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int cnt;
        wait_n(3);
        rst_n = 1'b1;

        // R1: reset state
        rd('h10, d);  check(d == 0, "R1", d, 0);
        rd('h110, d); check(d == 0, "R1", d, 0);
        check(irq_out == '0, "R1", int'(irq_out[31:0]), 0);

        // Table-driven mode checks on pin PIN
        for (int v = 0; v < 14; v++) begin
            logic [2:0] t; logic e, s0, s1, b; logic [3:0] c;
            {t, e, s0, s1, b, c} = VEC[v];
            wr('h110 + 4 * PIN, {29'b0, t});
            wr('h10, 32'(e) << PIN);
            @(negedge clk); irq_in[PIN] = s0;
            wait_n(6);
            check(irq_out[PIN] == b, tag_of(t, e), int'(irq_out[PIN]), int'(b));
            edge_count(PIN, s1, cnt);
            check(cnt == int'(c), tag_of(t, e), cnt, int'(c));
        end

        // R2: read-modify-write of one bit keeps the other bits of the word
        wr('h10, 32'h0000_000F);
        rd('h10, d); wr('h10, d | 32'h100);
        rd('h10, d); check(d == 32'h10F, "R2", d, 32'h10F);
        wr('h24, 32'hFFFF_FFFF);
        rd('h24, d); check(d == 32'hFF, "R2", d, 32'hFF);
        rd('h10, d); check(d == 32'h10F, "R2", d, 32'h10F);
        // Pin 167 (word 5, bit 7) in rising mode
        wr('h110 + 4 * 167, 32'h6);
        edge_count(167, 1'b1, cnt); check(cnt == 1, "R2", cnt, 1);

        // R3: type word for pin 167 keeps only bits [2:0]
        wr('h110 + 4 * 167, 32'hFFFF_FFFE);
        rd('h110 + 4 * 167, d); check(d == 32'h6, "R3", d, 6);

        // R11: unmapped addresses read zero and ignore writes
        wr('h28, 32'hFFFF_FFFF); rd('h28, d); check(d == 0, "R11", d, 0);
        wr('h3B0, 32'h7); rd('h3B0, d); check(d == 0, "R11", d, 0);
        wr('h0, 32'hFFFF_FFFF); rd('h0, d); check(d == 0, "R11", d, 0);
        wr('h12, 32'hFFFF_FFFF); rd('h10, d); check(d == 32'h10F, "R11", d, 32'h10F);

        // R9: enabling a pin whose input is already high gives no pulse
        wr('h10, 32'h0);
        wr('h110 + 4 * PIN, 32'h6);
        @(negedge clk); irq_in[PIN] = 1'b0; wait_n(6);
        @(negedge clk); irq_in[PIN] = 1'b1; wait_n(6);
        wr('h10, 32'h1 << PIN);
        cnt = 0;
        for (int i = 0; i < 8; i++) begin @(negedge clk); if (irq_out[PIN]) cnt++; end
        check(cnt == 0, "R9", cnt, 0);
        // R9: disabling a high level clears the output within one clock
        wr('h110 + 4 * PIN, 32'h4); wait_n(2);
        check(irq_out[PIN] == 1'b1, "R9", int'(irq_out[PIN]), 1);
        @(negedge clk); reg_wr = 1'b1; reg_addr = 12'h10; reg_wdata = 32'h0;
        @(negedge clk); reg_wr = 1'b0;
        @(negedge clk);
        check(irq_out[PIN] == 1'b0, "R9", int'(irq_out[PIN]), 0);

        // R1: reset in mid-run clears the enables again
        wr('h10, 32'hFFFF_FFFF);
        @(negedge clk); rst_n = 1'b0; wait_n(2); rst_n = 1'b1;
        rd('h10, d); check(d == 0, "R1", d, 0);
        rd('h110 + 4 * 167, d); check(d == 0, "R1", d, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule